// File: doc/BRIEF.md
# Exponent-Scaled Threshold Fault Detector

This block watches a stream of linear light-conversion codes and decides when the signal has stayed above an upper limit, or below a lower limit, for long enough to matter. Each limit is held in a compact form: a 12-bit mantissa and a 4-bit exponent. The block expands each limit to a linear code by shifting the mantissa left by eight plus the exponent. Zeros fill the vacated low bits.

On every cycle that carries a valid sample, the block compares the sample against both expanded limits. A count of back-to-back violations is kept for each direction. When a count reaches the programmed persistence, the matching flag goes high. The flag stays high until software pulses a clear. Both expanded limits are also driven out, so neighbouring logic can reuse them.

Top module: `thr_fault_det`

## Requirements
- R1: `hi_lin` equals `hi_mant` shifted left by (8 + `hi_exp`) and zero-filled in a 35-bit word. For example, mantissa 0xFFF with exponent 15 gives 0x7FF800000.
- R2: `lo_lin` equals `lo_mant` shifted left by (8 + `lo_exp`) and zero-filled in a 35-bit word.
- R3: A valid sample is a high event only when its zero-extended code is strictly greater than `hi_lin`. A code equal to `hi_lin` is not an event.
- R4: A valid sample is a low event only when its code is strictly less than `lo_lin`. A code equal to `lo_lin` is not an event.
- R5: `persist_sel` values 0, 1, 2 and 3 select runs of 1, 2, 4 and 8 consecutive events. A flag becomes visible one clock after the edge that samples the event completing the run.
- R6: A valid sample that is not a high event returns the high run count to zero. The same holds for the low count with low events. An interrupted run therefore does not raise a flag.
- R7: Cycles with `smp_valid` low change neither the flags nor the run counts.
- R8: Flags are sticky. A `flag_clr` pulse drops both flags and both run counts to zero. The clear wins over a valid sample in the same cycle, and that sample is discarded.
- R9: A synchronous `rst` drives both flags and both counts to zero.
- R10: The high and low paths are independent. One sample may raise both flags when the low limit lies above the high limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | 28 | Linear conversion code |
| hi_mant | input | 12 | Upper limit mantissa |
| hi_exp | input | 4 | Upper limit exponent |
| lo_mant | input | 12 | Lower limit mantissa |
| lo_exp | input | 4 | Lower limit exponent |
| persist_sel | input | 2 | Run length select (1, 2, 4, 8) |
| flag_clr | input | 1 | Clears flags and run counts |
| flag_hi | output | 1 | Sticky upper-limit flag |
| flag_lo | output | 1 | Sticky lower-limit flag |
| hi_lin | output | 35 | Expanded upper limit |
| lo_lin | output | 35 | Expanded lower limit |

## Verification
Limit settings at the smallest and largest mantissa and exponent are used to test the expansion, including a shift of 23 that fills the top bit. Codes one below, equal to, and one above each limit separate strict from inclusive comparison. Runs at each persistence value, some broken by a normal sample and some padded with idle cycles, separate a consecutive-run count from a cumulative one and from a count that advances without a strobe. A clear that coincides with a violating sample, and a crossed-limit setting, show that the clear has priority and that the two directions are independent.

// File: rtl/thr_fault_det.sv
module thr_fault_det #(
  parameter int SAMPLE_W   = 28,
  parameter int MANT_W     = 12,
  parameter int EXP_W      = 4,
  parameter int SHIFT_BASE = 8,
  parameter int PERSIST_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic [SAMPLE_W-1:0]  smp_code,
  input  logic [MANT_W-1:0]    hi_mant,
  input  logic [EXP_W-1:0]     hi_exp,
  input  logic [MANT_W-1:0]    lo_mant,
  input  logic [EXP_W-1:0]     lo_exp,
  input  logic [PERSIST_W-1:0] persist_sel,
  input  logic                 flag_clr,
  output logic                 flag_hi,
  output logic                 flag_lo,
  output logic [MANT_W+SHIFT_BASE+(2**EXP_W)-2:0] hi_lin,
  output logic [MANT_W+SHIFT_BASE+(2**EXP_W)-2:0] lo_lin
);
  localparam int LIN_W   = MANT_W + SHIFT_BASE + (2**EXP_W) - 1;
  localparam int CNT_W   = 2**PERSIST_W;
  localparam int CNT_MAX = 2**((2**PERSIST_W) - 1);

  logic [LIN_W-1:0] code_x;
  logic [CNT_W-1:0] tgt, hi_cnt, lo_cnt, hi_nxt, lo_nxt;
  logic             hi_ev, lo_ev;

  assign hi_lin = LIN_W'(hi_mant) << (SHIFT_BASE + 32'(hi_exp));
  assign lo_lin = LIN_W'(lo_mant) << (SHIFT_BASE + 32'(lo_exp));
  assign code_x = LIN_W'(smp_code);
  assign hi_ev  = code_x > hi_lin;
  assign lo_ev  = code_x < lo_lin;
  assign tgt    = CNT_W'(1) << persist_sel;

  assign hi_nxt = !hi_ev ? '0 : (hi_cnt >= tgt) ? tgt : hi_cnt + 1'b1;
  assign lo_nxt = !lo_ev ? '0 : (lo_cnt >= tgt) ? tgt : lo_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || flag_clr) begin
      hi_cnt  <= '0;
      lo_cnt  <= '0;
      flag_hi <= 1'b0;
      flag_lo <= 1'b0;
    end else if (smp_valid) begin
      hi_cnt <= hi_nxt;
      lo_cnt <= lo_nxt;
      if (hi_nxt >= tgt) flag_hi <= 1'b1;
      if (lo_nxt >= tgt) flag_lo <= 1'b1;
    end
  end

  // R5/R3: a rising high flag needs a valid violating sample the cycle before
  a_r5_hi_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_hi) |-> $past(smp_valid && !flag_clr && (LIN_W'(smp_code) > hi_lin)));
  // R5/R4
  a_r5_lo_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_lo) |-> $past(smp_valid && !flag_clr && (LIN_W'(smp_code) < lo_lin)));
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_hi || flag_lo) && !flag_clr |=> $past(flag_hi) <= flag_hi && $past(flag_lo) <= flag_lo);
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> !flag_hi && !flag_lo && hi_cnt == '0 && lo_cnt == '0);
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_valid && !flag_clr |=> $stable(flag_hi) && $stable(flag_lo) && $stable(hi_cnt) && $stable(lo_cnt));
  a_r6_bounded: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= CNT_W'(CNT_MAX) && lo_cnt <= CNT_W'(CNT_MAX));
  a_r9_reset: assert property (@(posedge clk)
    rst |=> !flag_hi && !flag_lo && hi_cnt == '0 && lo_cnt == '0);
endmodule

// File: tb/thr_fault_det_tb.sv
`timescale 1ns/100ps
module thr_fault_det_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [27:0] smp_code = '0;
  logic [11:0] hi_mant = '0, lo_mant = '0;
  logic [3:0]  hi_exp = '0, lo_exp = '0;
  logic [1:0]  persist_sel = '0;
  logic        flag_clr = 1'b0;
  logic        flag_hi, flag_lo;
  logic [34:0] hi_lin, lo_lin;

  int checks = 0, errors = 0;

  typedef struct { logic hi; logic lo; string req; } exp_t;
  exp_t sb_q[$];

  int m_hc = 0, m_lc = 0;
  logic m_fh = 0, m_fl = 0;

  always #2.5 clk = ~clk;

  thr_fault_det dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
    .hi_mant(hi_mant), .hi_exp(hi_exp), .lo_mant(lo_mant), .lo_exp(lo_exp),
    .persist_sel(persist_sel), .flag_clr(flag_clr),
    .flag_hi(flag_hi), .flag_lo(flag_lo), .hi_lin(hi_lin), .lo_lin(lo_lin));

  function automatic logic [34:0] expand(input logic [11:0] m, input logic [3:0] e);
    logic [34:0] r = {23'd0, m};
    for (int i = 0; i < 8 + int'(e); i++) r = {r[33:0], 1'b0};
    return r;
  endfunction

  task automatic step(input logic v, input logic [27:0] code, input logic clr, input string req);
    logic [34:0] c, th, tl;
    int tgt;
    @(negedge clk);
    smp_valid = v; smp_code = code; flag_clr = clr;
    @(posedge clk);
    c = {7'd0, code};
    th = expand(hi_mant, hi_exp);
    tl = expand(lo_mant, lo_exp);
    tgt = 1 << persist_sel;
    if (clr) begin
      m_hc = 0; m_lc = 0; m_fh = 0; m_fl = 0;
    end else if (v) begin
      m_hc = (c > th) ? ((m_hc + 1 > tgt) ? tgt : m_hc + 1) : 0;
      m_lc = (c < tl) ? ((m_lc + 1 > tgt) ? tgt : m_lc + 1) : 0;
      if (m_hc >= tgt) m_fh = 1;
      if (m_lc >= tgt) m_fl = 1;
    end
    sb_q.push_back('{m_fh, m_fl, req});
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (flag_hi !== e.hi || flag_lo !== e.lo) begin
        errors++;
        $display("FAIL %s: flags hi/lo actual %b%b expected %b%b", e.req, flag_hi, flag_lo, e.hi, e.lo);
      end
    end
  end

  task automatic check_lin(input logic [11:0] hm, input logic [3:0] he,
                           input logic [11:0] lm, input logic [3:0] le,
                           input logic [34:0] eh, input logic [34:0] el);
    @(negedge clk);
    hi_mant = hm; hi_exp = he; lo_mant = lm; lo_exp = le;
    #1;
    checks++;
    if (hi_lin !== eh) begin errors++; $display("FAIL R1: hi_lin actual %h expected %h", hi_lin, eh); end
    checks++;
    if (lo_lin !== el) begin errors++; $display("FAIL R2: lo_lin actual %h expected %h", lo_lin, el); end
  endtask

  task automatic clear_all();
    step(1'b0, 28'd0, 1'b1, "R8 clear");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (flag_hi !== 1'b0 || flag_lo !== 1'b0) begin
      errors++; $display("FAIL R9: flags actual %b%b expected 00", flag_hi, flag_lo);
    end

    check_lin(12'hFFF, 4'd15, 12'h001, 4'd0, 35'h7FF800000, 35'd256);   // R1 R2 extremes
    check_lin(12'hABC, 4'd3,  12'h800, 4'd15, 35'hABC << 11, 35'h400000000);
    check_lin(12'h010, 4'd2,  12'h004, 4'd0, 35'd16384, 35'd1024);

    // R5 persistence 1, R3 strict greater
    persist_sel = 2'd0;
    step(1'b1, 28'd16384, 1'b0, "R3 equal high");
    step(1'b1, 28'd16385, 1'b0, "R5 sel0 high");
    clear_all();

    // R5 persistence 2
    persist_sel = 2'd1;
    step(1'b1, 28'd20000, 1'b0, "R5 sel1 first");
    step(1'b1, 28'd20000, 1'b0, "R5 sel1 second");
    clear_all();

    // R6 broken run at persistence 4
    persist_sel = 2'd2;
    step(1'b1, 28'd20000, 1'b0, "R6 run");
    step(1'b1, 28'd20000, 1'b0, "R6 run");
    step(1'b1, 28'd2000,  1'b0, "R6 break");
    for (int i = 0; i < 3; i++) step(1'b1, 28'd20000, 1'b0, "R6 after break");
    step(1'b1, 28'd20000, 1'b0, "R5 sel2 fourth");
    clear_all();

    // R7 idle cycles keep run count
    persist_sel = 2'd1;
    step(1'b1, 28'd30000, 1'b0, "R7 first");
    for (int i = 0; i < 3; i++) step(1'b0, 28'd30000, 1'b0, "R7 idle");
    step(1'b1, 28'd30000, 1'b0, "R7 second");
    clear_all();

    // R4 strict less, persistence 8
    persist_sel = 2'd3;
    step(1'b1, 28'd1024, 1'b0, "R4 equal low");
    for (int i = 0; i < 7; i++) step(1'b1, 28'd1023, 1'b0, "R4 low run");
    step(1'b1, 28'd0, 1'b0, "R5 sel3 eighth");

    // R8 sticky and clear priority
    for (int i = 0; i < 3; i++) step(1'b1, 28'd5000, 1'b0, "R8 sticky");
    persist_sel = 2'd1;
    step(1'b1, 28'd20000, 1'b1, "R8 clear wins");
    step(1'b1, 28'd20000, 1'b0, "R8 count was cleared");
    step(1'b1, 28'd20000, 1'b0, "R8 run resumes");
    clear_all();

    // R10 crossed limits, both directions at once
    check_lin(12'h010, 4'd2, 12'h100, 4'd0, 35'd16384, 35'd65536);
    persist_sel = 2'd0;
    step(1'b1, 28'd20000, 1'b0, "R10 both");

    // R9 reset mid-operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_hc = 0; m_lc = 0; m_fh = 0; m_fl = 0;
    checks++;
    if (flag_hi !== 1'b0 || flag_lo !== 1'b0) begin
      errors++; $display("FAIL R9: flags after reset actual %b%b expected 00", flag_hi, flag_lo);
    end

    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule